// File: doc/BRIEF.md
# Backplane-to-T1 Channel Selector Elastic Store

This block takes a serial backplane that carries 32 eight-bit time slots per frame and turns it into a T1-style transmit stream. That stream carries 24 eight-bit channels plus one framing-bit position per 193-bit frame. A 32-bit ignore mask has one bit per backplane channel. The backplane channels that are not ignored are packed, in ascending order, onto T1 channels 1 to 24. The block is meant for a transmit path where a wide backplane feeds a narrower line.

Both serial sides run on one core clock. Each side has its own bit strobe (`bpEn`, `t1En`) and its own frame-start strobe. Each completed backplane frame is written into one half of a two-frame buffer. A T1 frame always reads the half that was completed most recently. The value of the framing bit is taken from an input port. A mode-enable input turns the mask on. When the mode is off, backplane channels 1 to 24 pass straight through. A configuration-error flag is raised whenever the mask leaves a number of channels other than 24.

Top module: `chanSelStore`

## Requirements
- R1: After reset, `t1Data` is 1 and `cfgErr` is 0. After reset the mask ignores backplane channels 25 to 32 (mask bits 24 to 31 set, all other bits clear).
- R2: A write with `maskWe` high stores `maskData` into mask byte `maskAddr`. Bit b of byte n governs backplane channel 8n+b+1, and a 1 means that channel is ignored. Writing byte 3 = FCh ignores channels 27 to 32.
- R3: With `modeEn` high, the backplane channels that are not ignored fill T1 channels 1 to 24 in ascending backplane order. On both serial sides, data is carried MSB first within each eight-bit channel.
- R4: If fewer than 24 channels are kept, the T1 channels left over carry all ones. If more than 24 are kept, only the lowest 24 are used.
- R5: One cycle after the mask or `modeEn` settles, `cfgErr` is 1 exactly when `modeEn` is 1 and the number of cleared mask bits differs from 24.
- R6: With `modeEn` low, the mask has no effect: backplane channels 1 to 24 map one-to-one onto T1 channels 1 to 24.
- R7: The bit that leaves on the `t1En` cycle carrying `t1Sync` is the framing bit. Its value is `fBit` sampled in that cycle. It is followed by the 192 channel bits of that frame.
- R8: `bpSync` marks bit 0 of backplane slot 1. A T1 frame reads the most recent complete backplane frame, and this includes a frame whose last bit is strobed in the same cycle as `t1Sync`.
- R9: If no backplane frame has been completed since reset, every channel bit of a T1 frame is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeEn | input | 1 | Enables mask-based channel selection |
| maskWe | input | 1 | Mask byte write strobe |
| maskAddr | input | 2 | Mask byte index |
| maskData | input | 8 | Mask byte value, 1 = ignore channel |
| bpEn | input | 1 | Backplane bit strobe |
| bpSync | input | 1 | Backplane frame start, marks slot 1 bit 0 |
| bpData | input | 1 | Backplane serial data |
| t1En | input | 1 | T1 bit strobe |
| t1Sync | input | 1 | T1 frame start, marks the framing-bit position |
| fBit | input | 1 | Framing-bit value |
| t1Data | output | 1 | T1 serial data, registered |
| cfgErr | output | 1 | Kept-channel count differs from 24 |

## Verification
The risky coincidence is a T1 frame start arriving in the very cycle in which the last bit of a backplane frame completes its buffer half. In that case the reader has to take the fresh half, not the half the writer is about to reuse. The bench provokes this by placing `t1Sync` on backplane bit 255 and requires that the T1 frame carry that same backplane frame, bit for bit. Other scenarios place the frame start early and late in the following backplane frame, where the previous frame is expected.

// File: rtl/selPkg.sv
package selPkg;
  typedef struct packed {
    logic bpShift;   // backplane bit taken this cycle
    logic keep;      // completed slot is to be stored
    logic frameDone; // last backplane bit of the frame
    logic rdStart;   // T1 framing-bit position this cycle
    logic rdStep;    // T1 bit leaves this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/selCtrl.sv
module selCtrl
  import selPkg::*;
#(
  parameter int IN_SLOTS  = 32,
  parameter int OUT_SLOTS = 24,
  parameter int SB        = 8,
  parameter int AW        = 2,
  parameter int PW        = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeEn,
  input  logic          maskWe,
  input  logic [AW-1:0] maskAddr,
  input  logic [7:0]    maskData,
  input  logic          bpEn,
  input  logic          bpSync,
  input  logic          t1En,
  input  logic          t1Sync,
  output ctrlStrobe_t   strb,
  output logic [PW-1:0] rdPos,
  output logic          cfgErr
);
  localparam int IN_BITS  = IN_SLOTS * SB;
  localparam int OUT_BITS = OUT_SLOTS * SB + 1;
  localparam int BW       = $clog2(IN_BITS);
  localparam int BYTES    = IN_SLOTS / 8;
  localparam int CW       = $clog2(IN_SLOTS + 1);

  logic [7:0]          maskB [BYTES];
  logic [IN_SLOTS-1:0] mask;
  logic [BW-1:0]       bpPos, bpCur;
  logic [PW-1:0]       t1Pos, t1Cur;
  logic [BW-1:0]       chSel;
  logic                keepCh;
  logic [CW-1:0]       keptCnt;

  // Mask storage, one register per byte lane
  for (genvar g = 0; g < BYTES; g++) begin : gLane
    localparam logic [7:0] RST_BYTE = (g * 8 >= OUT_SLOTS) ? 8'hFF : 8'h00;
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) maskB[g] <= RST_BYTE;
      else if (maskWe && maskAddr == AW'(g)) maskB[g] <= maskData;
    assign mask[g*8 +: 8] = maskB[g];

    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rstN)
      (maskWe && maskAddr == AW'(g)) |=> maskB[g] == $past(maskData));
  end

  // Backplane bit position
  always_comb begin
    if (bpSync) bpCur = '0;
    else if (bpPos == BW'(IN_BITS - 1)) bpCur = '0;
    else bpCur = bpPos + 1'b1;
    chSel  = bpCur / BW'(SB);
    keepCh = modeEn ? !mask[chSel] : (chSel < BW'(OUT_SLOTS));
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) bpPos <= BW'(IN_BITS - 1);
    else if (bpEn) bpPos <= bpCur;

  // T1 bit position, 0 is the framing bit
  always_comb begin
    if (t1Sync) t1Cur = '0;
    else if (t1Pos == PW'(OUT_BITS - 1)) t1Cur = '0;
    else t1Cur = t1Pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) t1Pos <= PW'(OUT_BITS - 1);
    else if (t1En) t1Pos <= t1Cur;

  assign strb.bpShift   = bpEn;
  assign strb.keep      = bpEn && (bpCur % BW'(SB) == BW'(SB - 1)) && keepCh;
  assign strb.frameDone = bpEn && (bpCur == BW'(IN_BITS - 1));
  assign strb.rdStart   = t1En && (t1Cur == '0);
  assign strb.rdStep    = t1En;
  assign rdPos          = t1Cur;

  // Kept-channel count check
  always_comb begin
    keptCnt = '0;
    for (int i = 0; i < IN_SLOTS; i++) keptCnt = keptCnt + CW'(!mask[i]);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) cfgErr <= 1'b0;
    else cfgErr <= modeEn && (keptCnt != CW'(OUT_SLOTS));

  a_r8_pos_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (bpEn && !bpSync && $past(bpEn) && bpPos == BW'(IN_BITS - 1)) |=> bpPos == '0);
endmodule

// File: rtl/selPath.sv
module selPath
  import selPkg::*;
#(
  parameter int OUT_SLOTS = 24,
  parameter int SB        = 8,
  parameter int PW        = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bpData,
  input  logic          fBit,
  input  ctrlStrobe_t   strb,
  input  logic [PW-1:0] rdPos,
  output logic          t1Data
);
  localparam int IW  = $clog2(OUT_SLOTS + 1);
  localparam int SLW = $clog2(OUT_SLOTS);
  localparam int BTW = $clog2(SB);

  logic [SB-1:0]  mem [2][OUT_SLOTS];
  logic [SB-2:0]  sr;
  logic [SB-1:0]  byteIn;
  logic           wrHalf, doneHalf, rdHalfQ, selHalf;
  logic [IW-1:0]  wrIdx;
  logic [IW-1:0]  fill [2];
  logic           doWrite;
  logic [PW-1:0]  q, slot;
  logic [SLW-1:0] slotIdx;
  logic [BTW-1:0] bitSel;
  logic           slotOk, outBit;

  assign byteIn  = {sr, bpData};
  assign doWrite = strb.keep && (wrIdx < IW'(OUT_SLOTS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sr <= '0;
    else if (strb.bpShift) sr <= byteIn[SB-2:0];

  always_ff @(posedge clk)
    if (doWrite) mem[wrHalf][wrIdx[SLW-1:0]] <= byteIn;

  // Write side: fill index and half bookkeeping
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wrIdx    <= '0;
      wrHalf   <= 1'b0;
      doneHalf <= 1'b1;
      fill[0]  <= '0;
      fill[1]  <= '0;
    end else begin
      if (doWrite) wrIdx <= wrIdx + 1'b1;
      if (strb.frameDone) begin
        fill[wrHalf] <= wrIdx + IW'(doWrite);
        doneHalf     <= wrHalf;
        wrHalf       <= !wrHalf;
        wrIdx        <= '0;
      end
    end

  // Read side: a frame start takes the half completing in the same cycle
  always_comb begin
    if (strb.rdStart) selHalf = strb.frameDone ? wrHalf : doneHalf;
    else selHalf = rdHalfQ;
    q       = rdPos - 1'b1;
    slot    = q / PW'(SB);
    slotOk  = slot < PW'(OUT_SLOTS);
    slotIdx = slotOk ? slot[SLW-1:0] : '0;
    bitSel  = BTW'(SB - 1) - BTW'(q % PW'(SB));
    if (rdPos == '0) outBit = fBit;
    else if (slotOk && (IW'(slotIdx) < fill[selHalf])) outBit = mem[selHalf][slotIdx][bitSel];
    else outBit = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rdHalfQ <= 1'b1;
      t1Data  <= 1'b1;
    end else begin
      if (strb.rdStart) rdHalfQ <= selHalf;
      if (strb.rdStep) t1Data <= outBit;
    end

  a_r7_fbit_out: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStart |=> t1Data == $past(fBit));
  a_r4_fill_cap: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx <= IW'(OUT_SLOTS));
  a_r8_half_flip: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> (wrHalf != $past(wrHalf)) && (doneHalf == $past(wrHalf)));
  a_r9_blank_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStep && !strb.rdStart && rdPos != '0 && fill[rdHalfQ] == '0) |=> t1Data);
endmodule

// File: rtl/chanSelStore.sv
module chanSelStore
  import selPkg::*;
#(
  parameter int IN_SLOTS  = 32,
  parameter int OUT_SLOTS = 24,
  parameter int SB        = 8,
  localparam int AW = $clog2((IN_SLOTS / 8) > 1 ? (IN_SLOTS / 8) : 2),
  localparam int PW = $clog2(OUT_SLOTS * SB + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeEn,
  input  logic          maskWe,
  input  logic [AW-1:0] maskAddr,
  input  logic [7:0]    maskData,
  input  logic          bpEn,
  input  logic          bpSync,
  input  logic          bpData,
  input  logic          t1En,
  input  logic          t1Sync,
  input  logic          fBit,
  output logic          t1Data,
  output logic          cfgErr
);
  ctrlStrobe_t   strb;
  logic [PW-1:0] rdPos;

  selCtrl #(.IN_SLOTS(IN_SLOTS), .OUT_SLOTS(OUT_SLOTS), .SB(SB), .AW(AW), .PW(PW)) uCtrl (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .maskWe(maskWe), .maskAddr(maskAddr),
    .maskData(maskData), .bpEn(bpEn), .bpSync(bpSync), .t1En(t1En), .t1Sync(t1Sync),
    .strb(strb), .rdPos(rdPos), .cfgErr(cfgErr)
  );

  selPath #(.OUT_SLOTS(OUT_SLOTS), .SB(SB), .PW(PW)) uPath (
    .clk(clk), .rstN(rstN), .bpData(bpData), .fBit(fBit), .strb(strb),
    .rdPos(rdPos), .t1Data(t1Data)
  );
endmodule

// File: tb/sim_chanSelStore.sv
module sim_chanSelStore;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, modeEn = 1'b1, maskWe = 1'b0;
  logic [1:0] maskAddr = '0;
  logic [7:0] maskData = '0;
  logic bpEn = 1'b0, bpSync = 1'b0, bpData = 1'b0;
  logic t1En = 1'b0, t1Sync = 1'b0, fBit = 1'b0;
  logic t1Data, cfgErr;
  int checks = 0, errors = 0;

  always #(PERIOD / 2) clk = ~clk;

  chanSelStore u0 (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .maskWe(maskWe), .maskAddr(maskAddr),
    .maskData(maskData), .bpEn(bpEn), .bpSync(bpSync), .bpData(bpData),
    .t1En(t1En), .t1Sync(t1Sync), .fBit(fBit), .t1Data(t1Data), .cfgErr(cfgErr)
  );

  function automatic logic [7:0] bpByte(int f, int ch);
    return 8'(f * 73 + ch * 29 + 17);
  endfunction

  task automatic check(bit ok, string tag, logic [192:0] act, logic [192:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One scenario: reset, optional mask write, three backplane frames,
  // one T1 frame starting at cycle s of the backplane run.
  task automatic scenario(string tag, bit mode, bit wr, logic [31:0] m, int s, bit fb);
    logic [31:0] effMask;
    logic [192:0] got, exp;
    int kept[$];
    int f;
    bit errExp;
    modeEn = mode;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    if (wr) begin
      for (int b = 0; b < 4; b++) begin
        maskWe = 1'b1; maskAddr = 2'(b); maskData = m[b*8 +: 8];
        @(negedge clk);
      end
      maskWe = 1'b0;
    end
    @(negedge clk);
    effMask = wr ? m : 32'hFF00_0000;
    errExp = mode && ($countones(~effMask) != 24);
    check(cfgErr == errExp, {tag, " R5 cfgErr"}, 193'(cfgErr), 193'(errExp));
    // expected T1 frame
    f = (s + 1) / 256 - 1;
    for (int c = 0; c < 32; c++)
      if (mode ? !effMask[c] : (c < 24)) kept.push_back(c);
    exp = '1;
    exp[0] = fb;
    for (int sl = 0; sl < 24; sl++)
      for (int b = 0; b < 8; b++)
        exp[1 + sl*8 + b] = (f >= 0 && sl < kept.size()) ? bpByte(f, kept[sl])[7-b] : 1'b1;
    got = '0;
    for (int t = 0; t < 768; t++) begin
      bpEn = 1'b1;
      bpSync = (t % 256 == 0);
      bpData = bpByte(t / 256, (t % 256) / 8)[7 - t % 8];
      t1En = (t >= s && t < s + 193);
      t1Sync = (t == s);
      fBit = (t == s) ? fb : ~fb;
      @(posedge clk);
      @(negedge clk);
      if (t >= s && t < s + 193) got[t - s] = t1Data;
    end
    bpEn = 1'b0; bpSync = 1'b0; t1En = 1'b0; t1Sync = 1'b0;
    check(got == exp, {tag, " frame"}, got, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check(t1Data == 1'b1, "R1 t1Data reset", 193'(t1Data), 193'(1));
    check(cfgErr == 1'b0, "R1 cfgErr reset", 193'(cfgErr), 193'(0));
    // R1 R3: default mask, read frame 0 early in frame 1
    scenario("R1 R3 default mask", 1'b1, 1'b0, 32'h0, 266, 1'b1);
    // R2 R3 R8: channels 1, 17, 27-32 ignored; frame start on last bit of frame 1
    scenario("R2 R8 collision", 1'b1, 1'b1, 32'hFC01_0001, 511, 1'b0);
    // R2 R3: distributed ignore pattern, late start
    scenario("R2 R3 spread", 1'b1, 1'b1, 32'h1111_1111, 318, 1'b1);
    // R4 R5: only four ignored, 28 kept, lowest 24 used
    scenario("R4 excess kept", 1'b1, 1'b1, 32'hF000_0000, 300, 1'b0);
    // R4 R5: twelve ignored, 20 kept, tail slots all ones
    scenario("R4 short kept", 1'b1, 1'b1, 32'h0000_0FFF, 255, 1'b1);
    // R6: mode off, mask disregarded
    scenario("R6 mode off", 1'b0, 1'b1, 32'hFC01_0001, 280, 1'b0);
    // R9: read before any backplane frame completes
    scenario("R9 empty store", 1'b1, 1'b0, 32'h0, 40, 1'b1);
    // R7: framing bit of both polarities covered above; R5 mode-off error flag
    scenario("R5 R7 mode off miscount", 1'b0, 1'b1, 32'h0000_0000, 260, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule